// File: doc/BRIEF.md
# Processor Sleep and Wake-Event Controller

This block decides when a small processor core stops and when it resumes. The core signals a wait-for-event or wait-for-interrupt request, or the return from an exception handler to thread code. The controller then either halts the core or lets it continue. While the core is halted it watches the wake sources: interrupt pending pulses, an event-send strobe and an external event pin. When a qualifying source appears, it releases the core with a one-cycle wake pulse.

A three-bit control register sets the policy. One bit lets interrupts whose enable bit is off still count as wake sources. One bit chooses between ordinary and deep sleep. One bit makes the core go back to sleep by itself when a handler returns to thread mode. A one-bit event latch holds an event that arrives while no wait-for-event is in progress, so that the next wait-for-event returns at once.

The state machine has five states. `ST_RUN` means the core executes. `ST_WFE` means asleep in wait-for-event. `ST_WFI` means asleep in wait-for-interrupt. `ST_EXIT` means asleep after a handler return. `ST_WAKE` is the single resume cycle.

The transitions are:
- `ST_RUN`→`ST_WFE` on a wait-for-event request when the latch is empty and no event arrives in that cycle.
- `ST_RUN`→`ST_RUN` on a wait-for-event request that consumes an event.
- `ST_RUN`→`ST_WFI` on a wait-for-interrupt request.
- `ST_RUN`→`ST_EXIT` on a handler return while sleep-on-exit is set.
- `ST_WFE`→`ST_WAKE` on any event.
- `ST_WFI`→`ST_WAKE` and `ST_EXIT`→`ST_WAKE` on a qualifying interrupt.
- `ST_WAKE`→`ST_RUN` always.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the control bits and the event latch are 0. The core is running, and `sleeping`, `deep_sleep`, `wake_pulse` and `core_halt` are all 0.
- R2: Address 0 holds the control register, with bit 0 = wake-on-any-pending, bit 1 = deep-sleep select and bit 2 = sleep-on-exit. A write takes effect on the next clock edge, and the upper data bits read as 0 and ignore writes. Address 1 reads the event latch in bit 0, is read-only and ignores writes. All other addresses read 0. Reads are combinational from `reg_addr`.
- R3: With wake-on-any-pending at 0, a pending pulse on an interrupt whose enable bit is 1 is an event. A pending pulse on a disabled interrupt is ignored, and a sleeping core stays asleep.
- R4: With wake-on-any-pending at 1, a pending pulse on any interrupt, enabled or not, is an event. It wakes the core from either sleep kind.
- R5: `sev_strobe` or `ext_event` is always an event, and it wakes a core sleeping in wait-for-event.
- R6: An event that arrives while the core is not asleep in wait-for-event, and not in the cycle of a wait-for-event request, sets the latch. A later wait-for-event request then does not sleep.
- R7: A wait-for-event request while running clears the latch. If the latch was 0 and no event arrives in that cycle, the core is asleep on the next cycle. A wake from wait-for-event leaves the latch at 0.
- R8: Wait-for-interrupt sleep and sleep-on-exit sleep ignore the latch, `sev_strobe` and `ext_event`. They end only on a qualifying interrupt pending pulse.
- R9: `deep_sleep` is 1 exactly while asleep with the deep-sleep bit at 1.
- R10: A handler-return strobe while running, with sleep-on-exit at 1, puts the core to sleep on the next cycle. With the bit at 0 the strobe has no effect.
- R11: When a wake condition is sampled at a clock edge, `sleeping` is 0 after that edge and `wake_pulse` is 1 for exactly one cycle. The core then runs. `core_halt` equals `sleeping` at all times.
- R12: While running, wait-for-event takes priority over wait-for-interrupt, which takes priority over handler return. Requests made in a sleep state or in the wake cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| wfe_req | input | 1 | Wait-for-event request |
| wfi_req | input | 1 | Wait-for-interrupt request |
| sev_strobe | input | 1 | Event-send instruction strobe |
| ext_event | input | 1 | External event input |
| exc_ret_thread | input | 1 | Handler-to-thread return strobe |
| irq_pend | input | NUM_IRQ | Per-interrupt pending-entry pulses |
| irq_en | input | NUM_IRQ | Per-interrupt enable bits |
| sleeping | output | 1 | Core is in a sleep state |
| deep_sleep | output | 1 | Sleeping with deep sleep selected |
| wake_pulse | output | 1 | One-cycle wake indication |
| core_halt | output | 1 | Halt request to the core |

## Verification
The bench builds the block with `NUM_IRQ=4`, `ADDR_W=2` and `DATA_W=8`. With only four interrupt lines, random pending pulses and enable patterns land on both enabled and disabled lines within a few cycles. This exercises the wake-on-any-pending distinction in every sleep kind. The two-bit address reaches the control register, the read-only latch view and the two unmapped addresses, so the zero reads are exercised. With eight data bits, writes of all ones probe the reserved bits.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_WFE  = 3'd1,
        ST_WFI  = 3'd2,
        ST_EXIT = 3'd3,
        ST_WAKE = 3'd4
    } swc_state_e;

    localparam int CTL_ANYPEND = 0;
    localparam int CTL_DEEP    = 1;
    localparam int CTL_EXITSLP = 2;
    localparam int CTL_BITS    = 3;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_LATCH = 1;
endpackage

// File: rtl/swc_ctrl_regs.sv
module swc_ctrl_regs
    import swc_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_latch,
    output logic [DATA_W-1:0] rdata,
    output logic              ctl_anypend,
    output logic              ctl_deep,
    output logic              ctl_exitslp
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(ADDR_LATCH);

    logic [CTL_BITS-1:0] ctl_q;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:CTL_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            ctl_q <= wdata[CTL_BITS-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[CTL_BITS-1:0] = ctl_q;
        end else if (addr == A_LATCH) begin
            rdata[0] = evt_latch;
        end
    end

    assign ctl_anypend = ctl_q[CTL_ANYPEND];
    assign ctl_deep    = ctl_q[CTL_DEEP];
    assign ctl_exitslp = ctl_q[CTL_EXITSLP];

    // R2: a control write lands on the next edge
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL) |=> (ctl_q == $past(wdata[CTL_BITS-1:0])));

    // R2: without a control write the register holds
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_CTRL) |=> $stable(ctl_q));
endmodule

// File: rtl/swc_event_unit.sv
module swc_event_unit #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_anypend,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               sev_strobe,
    input  logic               ext_event,
    input  logic               wfe_exec,
    input  logic               wfe_asleep,
    output logic               irq_wake,
    output logic               evt_now,
    output logic               evt_latch
);
    logic [NUM_IRQ-1:0] irq_qual;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
        assign irq_qual[i] = irq_pend[i] & (irq_en[i] | ctl_anypend);
    end

    assign irq_wake = |irq_qual;
    assign evt_now  = irq_wake | sev_strobe | ext_event;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_latch <= 1'b0;
        end else if (wfe_exec) begin
            evt_latch <= 1'b0;
        end else if (wfe_asleep && evt_now) begin
            evt_latch <= 1'b0;
        end else if (evt_now) begin
            evt_latch <= 1'b1;
        end
    end

    // R7: executing wait-for-event always empties the latch
    p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wfe_exec |=> !evt_latch);

    // R6: an event outside wait-for-event is remembered
    p_latch_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_now && !wfe_exec && !wfe_asleep) |=> evt_latch);

    // R3: disabled interrupts never qualify unless any-pending is set
    p_disabled_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_anypend && (irq_pend & irq_en) == '0) |-> !irq_wake);
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfe_req,
    input  logic wfi_req,
    input  logic exc_ret_thread,
    input  logic ctl_deep,
    input  logic ctl_exitslp,
    input  logic evt_now,
    input  logic evt_latch,
    input  logic irq_wake,
    output logic wfe_exec,
    output logic wfe_asleep,
    output logic sleeping,
    output logic deep_sleep,
    output logic wake_pulse,
    output logic core_halt
);
    swc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfe_req) begin
                    state_d = (evt_latch || evt_now) ? ST_RUN : ST_WFE;
                end else if (wfi_req) begin
                    state_d = ST_WFI;
                end else if (exc_ret_thread && ctl_exitslp) begin
                    state_d = ST_EXIT;
                end
            end
            ST_WFE: begin
                if (evt_now) state_d = ST_WAKE;
            end
            ST_WFI, ST_EXIT: begin
                if (irq_wake) state_d = ST_WAKE;
            end
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        sleeping   = 1'b0;
        wake_pulse = 1'b0;
        unique case (state_q)
            ST_WFE, ST_WFI, ST_EXIT: sleeping = 1'b1;
            ST_WAKE:                 wake_pulse = 1'b1;
            ST_RUN:                  sleeping = 1'b0;
            default:                 sleeping = 1'b0;
        endcase
        deep_sleep = sleeping & ctl_deep;
        core_halt  = sleeping;
    end

    assign wfe_exec   = (state_q == ST_RUN) && wfe_req;
    assign wfe_asleep = (state_q == ST_WFE);

    // R11: the wake pulse never lasts two cycles
    p_wake_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R11: a sampled wake condition drops sleeping on the next cycle
    p_wake_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WFE && evt_now) || ((state_q == ST_WFI || state_q == ST_EXIT) && irq_wake))
        |=> (wake_pulse && !sleeping));

    // R8: non-interrupt events leave wait-for-interrupt sleep alone
    p_wfi_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WFI || state_q == ST_EXIT) && !irq_wake) |=> sleeping);

    // R10: handler return with sleep-on-exit sleeps next cycle
    p_exit_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wfe_req && !wfi_req && exc_ret_thread && ctl_exitslp) |=> sleeping);

    // R12: only the run state acts on requests
    p_wake_to_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (!sleeping && !wake_pulse));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               wfe_req,
    input  logic               wfi_req,
    input  logic               sev_strobe,
    input  logic               ext_event,
    input  logic               exc_ret_thread,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               sleeping,
    output logic               deep_sleep,
    output logic               wake_pulse,
    output logic               core_halt
);
    logic ctl_anypend, ctl_deep, ctl_exitslp;
    logic irq_wake, evt_now, evt_latch;
    logic wfe_exec, wfe_asleep;

    swc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .evt_latch   (evt_latch),
        .rdata       (reg_rdata),
        .ctl_anypend (ctl_anypend),
        .ctl_deep    (ctl_deep),
        .ctl_exitslp (ctl_exitslp)
    );

    swc_event_unit #(.NUM_IRQ(NUM_IRQ)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_anypend (ctl_anypend),
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .sev_strobe  (sev_strobe),
        .ext_event   (ext_event),
        .wfe_exec    (wfe_exec),
        .wfe_asleep  (wfe_asleep),
        .irq_wake    (irq_wake),
        .evt_now     (evt_now),
        .evt_latch   (evt_latch)
    );

    swc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wfe_req        (wfe_req),
        .wfi_req        (wfi_req),
        .exc_ret_thread (exc_ret_thread),
        .ctl_deep       (ctl_deep),
        .ctl_exitslp    (ctl_exitslp),
        .evt_now        (evt_now),
        .evt_latch      (evt_latch),
        .irq_wake       (irq_wake),
        .wfe_exec       (wfe_exec),
        .wfe_asleep     (wfe_asleep),
        .sleeping       (sleeping),
        .deep_sleep     (deep_sleep),
        .wake_pulse     (wake_pulse),
        .core_halt      (core_halt)
    );
endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
    localparam int NI = 4;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          wfe_req = 1'b0, wfi_req = 1'b0, sev_strobe = 1'b0;
    logic          ext_event = 1'b0, exc_ret_thread = 1'b0;
    logic [NI-1:0] irq_pend = '0, irq_en = '0;
    logic          sleeping, deep_sleep, wake_pulse, core_halt;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.NUM_IRQ(NI), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wfe_req(wfe_req),
        .wfi_req(wfi_req), .sev_strobe(sev_strobe), .ext_event(ext_event),
        .exc_ret_thread(exc_ret_thread), .irq_pend(irq_pend), .irq_en(irq_en),
        .sleeping(sleeping), .deep_sleep(deep_sleep), .wake_pulse(wake_pulse),
        .core_halt(core_halt)
    );

    // model: 0 run, 1 wfe, 2 wfi, 3 exit, 4 wake
    int       m_st;
    bit       m_lat;
    bit [2:0] m_ctl;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        reg_wr_en = 0; wfe_req = 0; wfi_req = 0; sev_strobe = 0;
        ext_event = 0; exc_ret_thread = 0; irq_pend = '0;
    endtask

    task automatic wr(input int a, input int d);
        reg_wr_en = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
        tick();
        reg_wr_en = 0;
    endtask

    function automatic int rd(input int a);
        return 0;
    endfunction

    task automatic expect_out(input string tag, input bit slp, input bit dp, input bit wk);
        chk(sleeping == slp, {tag, " sleeping"}, sleeping, slp);
        chk(deep_sleep == dp, {tag, " deep_sleep"}, deep_sleep, dp);
        chk(wake_pulse == wk, {tag, " wake_pulse"}, wake_pulse, wk);
        chk(core_halt == slp, {tag, " core_halt"}, core_halt, slp);
    endtask

    task automatic expect_rd(input string tag, input int a, input int exp);
        reg_addr = AW'(a);
        #1;
        chk(reg_rdata == DW'(exp), tag, reg_rdata, exp);
    endtask

    task automatic pulse_irq(input int line);
        irq_pend = '0;
        irq_pend[line] = 1'b1;
        tick();
        irq_pend = '0;
    endtask

    function automatic bit qual(input bit [NI-1:0] p, input bit [NI-1:0] e, input bit any);
        return |(p & (any ? {NI{1'b1}} : e));
    endfunction

    task automatic model_step(input bit w, input bit [AW-1:0] a, input bit [DW-1:0] d,
                              input bit fe, input bit fi, input bit sv, input bit ex,
                              input bit er, input bit [NI-1:0] p, input bit [NI-1:0] e);
        bit iq, ev;
        int ns;
        bit nl;
        iq = qual(p, e, m_ctl[0]);
        ev = iq | sv | ex;
        ns = m_st;
        case (m_st)
            0: if (fe) ns = (m_lat || ev) ? 0 : 1;
               else if (fi) ns = 2;
               else if (er && m_ctl[2]) ns = 3;
            1: if (ev) ns = 4;
            2, 3: if (iq) ns = 4;
            default: ns = 0;
        endcase
        nl = m_lat;
        if (m_st == 0 && fe) nl = 0;
        else if (m_st == 1 && ev) nl = 0;
        else if (ev) nl = 1;
        if (w && a == 0) m_ctl = d[2:0];
        m_st = ns;
        m_lat = nl;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd9137));
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        expect_out("R1 reset", 0, 0, 0);
        expect_rd("R1 ctrl after reset", 0, 0);
        expect_rd("R1 latch after reset", 1, 0);

        // R2 register map
        wr(0, 8'hFF);
        expect_rd("R2 reserved bits read zero", 0, 7);
        wr(1, 8'hFF);
        expect_rd("R2 latch view ignores writes", 1, 0);
        expect_rd("R2 unmapped addr 2", 2, 0);
        expect_rd("R2 unmapped addr 3", 3, 0);
        wr(0, 0);
        expect_rd("R2 ctrl cleared", 0, 0);

        // R7 wfe with empty latch sleeps
        wfe_req = 1; tick(); wfe_req = 0;
        expect_out("R7 wfe sleeps", 1, 0, 0);
        // R3 disabled interrupt ignored
        irq_en = '0;
        pulse_irq(1);
        expect_out("R3 disabled irq ignored", 1, 0, 0);
        expect_rd("R3 latch stays empty", 1, 0);
        irq_en = 4'b0100;
        pulse_irq(2);
        expect_out("R3 enabled irq wakes, R11 pulse", 0, 0, 1);
        tick();
        expect_out("R11 pulse one cycle", 0, 0, 0);
        expect_rd("R7 wake leaves latch 0", 1, 0);

        // R6 latched event consumed
        sev_strobe = 1; tick(); sev_strobe = 0;
        expect_rd("R6 sev sets latch", 1, 1);
        wfe_req = 1; tick(); wfe_req = 0;
        expect_out("R6 wfe consumes latch", 0, 0, 0);
        expect_rd("R7 wfe clears latch", 1, 0);

        // R5 external event wakes wfe
        wfe_req = 1; tick(); wfe_req = 0;
        expect_out("R5 asleep", 1, 0, 0);
        ext_event = 1; tick(); ext_event = 0;
        expect_out("R5 ext_event wakes", 0, 0, 1);
        tick();

        // R8 wfi ignores latch, sev, ext and disabled irq
        sev_strobe = 1; tick(); sev_strobe = 0;
        wfi_req = 1; tick(); wfi_req = 0;
        expect_out("R8 wfi sleeps despite latch", 1, 0, 0);
        sev_strobe = 1; tick(); sev_strobe = 0;
        expect_out("R8 sev ignored in wfi", 1, 0, 0);
        ext_event = 1; tick(); ext_event = 0;
        expect_out("R8 ext ignored in wfi", 1, 0, 0);
        irq_en = '0;
        pulse_irq(0);
        expect_out("R8 disabled irq ignored in wfi", 1, 0, 0);
        irq_en = 4'b0001;
        pulse_irq(0);
        expect_out("R8 enabled irq wakes wfi", 0, 0, 1);
        tick();

        // R4 any-pending mode
        irq_en = '0;
        wr(0, 1);
        wfi_req = 1; tick(); wfi_req = 0;
        pulse_irq(3);
        expect_out("R4 disabled irq wakes wfi", 0, 0, 1);
        tick();
        wfe_req = 1; tick(); wfe_req = 0;
        expect_out("R4 wfe consumes stale latch", 0, 0, 0);
        wfe_req = 1; tick(); wfe_req = 0;
        expect_out("R4 wfe asleep", 1, 0, 0);
        pulse_irq(1);
        expect_out("R4 disabled irq wakes wfe", 0, 0, 1);
        tick();

        // R9 deep sleep
        wr(0, 2);
        wfi_req = 1; tick(); wfi_req = 0;
        expect_out("R9 deep while asleep", 1, 1, 0);
        irq_en = 4'b0001;
        pulse_irq(0);
        expect_out("R9 deep drops on wake", 0, 0, 1);
        tick();

        // R10 sleep on exit
        wr(0, 4);
        exc_ret_thread = 1; tick(); exc_ret_thread = 0;
        expect_out("R10 exit sleeps", 1, 0, 0);
        sev_strobe = 1; tick(); sev_strobe = 0;
        expect_out("R8 sev ignored in exit sleep", 1, 0, 0);
        pulse_irq(0);
        expect_out("R10 irq wakes exit sleep", 0, 0, 1);
        tick();
        wr(0, 0);
        exc_ret_thread = 1; tick(); exc_ret_thread = 0;
        expect_out("R10 no sleep with bit clear", 0, 0, 0);

        // R12 priority: wfe over wfi
        wfe_req = 1; tick(); wfe_req = 0;  // drain latch
        wfe_req = 1; wfi_req = 1; exc_ret_thread = 1; tick(); quiet();
        expect_out("R12 combined request sleeps", 1, 0, 0);
        sev_strobe = 1; tick(); sev_strobe = 0;
        expect_out("R12 wfe chosen so sev wakes", 0, 0, 1);
        wfi_req = 1; tick(); wfi_req = 0;
        expect_out("R12 request in wake cycle ignored", 0, 0, 0);

        // random phase against the model
        quiet();
        rst_n = 0; tick(); rst_n = 1; tick();
        m_st = 0; m_lat = 0; m_ctl = 0;
        for (int i = 0; i < 4000; i++) begin
            bit w, fe, fi, sv, ex, er;
            bit [AW-1:0] a;
            bit [DW-1:0] d;
            bit [NI-1:0] p, e;
            w  = ($urandom % 20) == 0;
            a  = AW'($urandom);
            d  = DW'($urandom);
            fe = ($urandom % 8) == 0;
            fi = ($urandom % 12) == 0;
            sv = ($urandom % 16) == 0;
            ex = ($urandom % 16) == 0;
            er = ($urandom % 10) == 0;
            for (int k = 0; k < NI; k++) begin
                p[k] = ($urandom % 10) == 0;
                e[k] = $urandom % 2;
            end
            reg_wr_en = w; reg_addr = a; reg_wdata = d;
            wfe_req = fe; wfi_req = fi; sev_strobe = sv; ext_event = ex;
            exc_ret_thread = er; irq_pend = p; irq_en = e;
            model_step(w, a, d, fe, fi, sv, ex, er, p, e);
            tick();
            quiet();
            begin
                bit es;
                int er_d;
                es = (m_st >= 1 && m_st <= 3);
                expect_out("R11 R9 random", es, es & m_ctl[1], m_st == 4);
                er_d = (a == 0) ? int'(m_ctl) : (a == 1) ? int'(m_lat) : 0;
                #1;
                chk(reg_rdata == DW'(er_d), "R2 R6 random readback", reg_rdata, er_d);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule